// File: doc/BRIEF.md
# Termination Calibration Request Sequencer

This block sits between the core logic and a column of impedance calibration engines. Software or a core state machine raises bits in a request vector, one bit per engine. The sequencer takes a snapshot of that vector and starts every requested engine at once. It waits a fixed calibration time, then moves one channel at a time through a serial shift of that engine's code words into the termination logic. The channels go in ascending index order. Once every requested channel has been shifted, it raises a single-cycle load strobe that transfers the new codes into the I/O buffers.

The engines and the shift datapath are outside the block. The calibration time is modelled by an internal timer of `CAL_CYCLES` cycles. During a shift the block drives a shift enable and a one-hot channel select for `SHIFT_LEN` cycles. Two vectors report progress. `cal_busy` shows which engines are still calibrating. `shift_busy` shows which channels have not yet had their codes delivered. While any `shift_busy` bit is set, new requests are not accepted.

Top module: `cal_req_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `cal_busy`, `shift_busy`, `shift_sel`, `shift_en` and `load_strobe` after that edge and abandons any sequence in progress.
- R2: A request is accepted only when the same nonzero `cal_req` value is present at two consecutive rising edges. A value seen at a single edge, or a value that changes between edges, is not captured.
- R3: On acceptance, in the cycle after the second edge, both `cal_busy` and `shift_busy` equal the captured request vector. Bit i stands for channel i.
- R4: All requested engines calibrate together. `cal_busy` holds the captured vector for exactly `CAL_CYCLES` cycles, then clears to zero on one edge.
- R5: After calibration, each requested channel is shifted in ascending index order. `shift_en` stays high for exactly `SHIFT_LEN` consecutive cycles per channel, and `shift_sel` is one-hot with bit i set for channel i. `shift_sel` is zero whenever `shift_en` is low, and no shift happens while any `cal_busy` bit is set.
- R6: A channel's `shift_busy` bit clears two cycles after its last `shift_en` cycle. The retire cycle lies between the two. The other bits are unchanged.
- R7: `load_strobe` is high for exactly one cycle per accepted request, while both busy vectors are zero. Count edges from the accepting edge, with h the highest requested index and k the number of requested channels. The strobe is visible after edge `CAL_CYCLES + 2*h + 1 + (SHIFT_LEN+2)*k`.
- R8: A request presented while any `shift_busy` bit is set is ignored. No `shift_busy` or `cal_busy` bit rises, and the channels it names are not shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (20 MHz or slower so that one strobe cycle meets the buffer load width) |
| rst | input | 1 | Synchronous reset, active high |
| cal_req | input | NUM_CH | Per-channel calibration request, hold for two edges |
| cal_busy | output | NUM_CH | Channels whose engines are calibrating |
| shift_busy | output | NUM_CH | Channels whose code words are not yet delivered |
| shift_sel | output | NUM_CH | One-hot channel select during a serial shift |
| shift_en | output | 1 | Serial shift enable, high for SHIFT_LEN cycles per channel |
| load_strobe | output | 1 | One-cycle pulse that loads new codes into the buffers |

## Verification
The bench drives single channels at both ends of the index range, sparse masks, the full mask and adjacent pairs. A scan that skipped a bit, ran descending or stopped early would show a wrong shift order or a missing channel. An off-by-one in the empty-slot stepping would move the load strobe away from its computed edge. A one-cycle request pulse and a request that changes value between edges are aimed at a capture that does not wait for two matching edges. A request injected in mid-shift targets a design that re-arms while busy, which would raise foreign `shift_busy` bits. A reset asserted during calibration must leave every output quiet, with no later shift or strobe.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam int unsigned CH_MAX = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL,
    ST_CHECK,
    ST_STEP,
    ST_SHIFT,
    ST_RETIRE,
    ST_DONE
  } seq_state_e;

  // one-hot mask of a channel index, full width; callers slice it
  function automatic logic [CH_MAX-1:0] chan_bit(input int unsigned idx);
    chan_bit = CH_MAX'(1) << idx;
  endfunction

  // counter width that can hold a count up to n-1
  function automatic int unsigned count_width(input int unsigned n);
    count_width = (n > 1) ? $clog2(n) + 1 : 1;
  endfunction
endpackage

// File: rtl/cal_req_capture.sv
module cal_req_capture #(
  parameter int unsigned NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  output logic              req_held
);
  logic [NUM_CH-1:0] req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req;
  end

  // same nonzero value on two consecutive edges
  assign req_held = (req != '0) && (req == req_q);
endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] last,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == last);
endmodule

// File: rtl/cal_pending_scan.sv
module cal_pending_scan
  import cal_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned IW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NUM_CH-1:0] load_mask,
  input  logic              step,
  input  logic              retire,
  output logic              pend_cur,
  output logic              pend_any,
  output logic [IW-1:0]     idx,
  output logic [NUM_CH-1:0] cur_onehot
);
  logic [NUM_CH-1:0] pending;
  logic [CH_MAX-1:0] full_bit;

  assign full_bit   = chan_bit(int'(idx));
  assign cur_onehot = full_bit[NUM_CH-1:0];
  assign pend_cur   = |(pending & cur_onehot);
  assign pend_any   = |pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      idx     <= '0;
    end else if (load) begin
      pending <= load_mask;
      idx     <= '0;
    end else begin
      if (step)   idx     <= idx + 1'b1;
      if (retire) pending <= pending & ~cur_onehot;
    end
  end
endmodule

// File: rtl/cal_req_sequencer.sv
module cal_req_sequencer
  import cal_seq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 12,
  parameter int unsigned CAL_CYCLES = 2000,
  parameter int unsigned SHIFT_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cal_req,
  output logic [NUM_CH-1:0] cal_busy,
  output logic [NUM_CH-1:0] shift_busy,
  output logic [NUM_CH-1:0] shift_sel,
  output logic              shift_en,
  output logic              load_strobe
);
  localparam int unsigned IW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned LONG = (CAL_CYCLES > SHIFT_LEN) ? CAL_CYCLES : SHIFT_LEN;
  localparam int unsigned CW   = count_width(LONG);
  localparam logic [CW-1:0] CAL_LAST   = CW'(CAL_CYCLES - 1);
  localparam logic [CW-1:0] SHIFT_LAST = CW'(SHIFT_LEN - 1);

  seq_state_e state, state_nxt;

  logic              req_held;
  logic              t_run, t_expire;
  logic [CW-1:0]     t_last;
  logic              pend_cur, pend_any;
  logic [IW-1:0]     idx;
  logic [NUM_CH-1:0] cur_onehot;

  // named internal events, also used by the checker
  logic ev_capture, ev_cal_end, ev_step, ev_retire;

  assign ev_capture = (state == ST_IDLE) && req_held && (shift_busy == '0);
  assign ev_cal_end = (state == ST_CAL) && t_expire;
  assign ev_step    = (state == ST_STEP);
  assign ev_retire  = (state == ST_RETIRE);

  assign t_run  = (state == ST_CAL) || (state == ST_SHIFT);
  assign t_last = (state == ST_CAL) ? CAL_LAST : SHIFT_LAST;

  cal_req_capture #(.NUM_CH(NUM_CH)) u_cap (
    .clk(clk), .rst(rst), .req(cal_req), .req_held(req_held)
  );

  cal_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .run(t_run), .last(t_last), .expire(t_expire)
  );

  cal_pending_scan #(.NUM_CH(NUM_CH), .IW(IW)) u_scan (
    .clk(clk), .rst(rst), .load(ev_capture), .load_mask(cal_req),
    .step(ev_step), .retire(ev_retire), .pend_cur(pend_cur),
    .pend_any(pend_any), .idx(idx), .cur_onehot(cur_onehot)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:   if (ev_capture) state_nxt = ST_CAL;
      ST_CAL:    if (t_expire)   state_nxt = ST_CHECK;
      ST_CHECK: begin
        if (!pend_any)     state_nxt = ST_DONE;
        else if (pend_cur) state_nxt = ST_SHIFT;
        else               state_nxt = ST_STEP;
      end
      ST_STEP:   state_nxt = ST_CHECK;
      ST_SHIFT:  if (t_expire) state_nxt = ST_RETIRE;
      ST_RETIRE: state_nxt = ST_CHECK;
      ST_DONE:   state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  // per-channel busy flags
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        cal_busy[c]   <= 1'b0;
        shift_busy[c] <= 1'b0;
      end else begin
        if (ev_capture)      cal_busy[c] <= cal_req[c];
        else if (ev_cal_end) cal_busy[c] <= 1'b0;
        if (ev_capture)                    shift_busy[c] <= cal_req[c];
        else if (ev_retire && cur_onehot[c]) shift_busy[c] <= 1'b0;
      end
    end
  end

  assign shift_en    = (state == ST_SHIFT);
  assign shift_sel   = shift_en ? cur_onehot : '0;
  assign load_strobe = (state == ST_DONE);
endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker #(
  parameter int unsigned NUM_CH = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] cal_busy,
  input logic [NUM_CH-1:0] shift_busy,
  input logic [NUM_CH-1:0] shift_sel,
  input logic              shift_en,
  input logic              load_strobe,
  input logic              ev_capture,
  input logic              ev_cal_end,
  input logic              ev_retire,
  input logic [NUM_CH-1:0] cur_onehot
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (cal_busy == '0 && shift_busy == '0 && shift_sel == '0 && !shift_en && !load_strobe));

  a_r3_capture_loads: assert property (@(posedge clk) disable iff (rst)
    ev_capture |=> (cal_busy == shift_busy) && (cal_busy != '0));

  a_r4_cal_clears: assert property (@(posedge clk) disable iff (rst)
    ev_cal_end |=> (cal_busy == '0));

  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> ($countones(shift_sel) == 1) && ((shift_sel & ~shift_busy) == '0));

  a_r5_sel_idle: assert property (@(posedge clk) disable iff (rst)
    !shift_en |-> (shift_sel == '0));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (|cal_busy) |-> !shift_en);

  a_r6_retire_clears: assert property (@(posedge clk) disable iff (rst)
    ev_retire |=> ((shift_busy & $past(cur_onehot)) == '0));

  a_r7_strobe_clean: assert property (@(posedge clk) disable iff (rst)
    load_strobe |-> (shift_busy == '0) && (cal_busy == '0));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> !load_strobe);

  a_r8_no_rearm: assert property (@(posedge clk) disable iff (rst)
    (|shift_busy) |=> ((shift_busy & ~$past(shift_busy)) == '0));
endmodule

bind cal_req_sequencer cal_seq_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .cal_busy(cal_busy), .shift_busy(shift_busy),
  .shift_sel(shift_sel), .shift_en(shift_en), .load_strobe(load_strobe),
  .ev_capture(ev_capture), .ev_cal_end(ev_cal_end), .ev_retire(ev_retire),
  .cur_onehot(cur_onehot)
);

// File: tb/tb_cal_req_sequencer.sv
module tb_cal_req_sequencer;
  localparam int N     = 6;
  localparam int CAL   = 20;
  localparam int SHIFT = 32;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC  = 6;
  localparam logic [N-1:0] VEC [NVEC] = '{6'b000001, 6'b100000, 6'b010101,
                                         6'b111111, 6'b101000, 6'b000110};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cal_req = '0;
  logic [N-1:0] cal_busy, shift_busy, shift_sel;
  logic shift_en, load_strobe;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_req_sequencer #(.NUM_CH(N), .CAL_CYCLES(CAL), .SHIFT_LEN(SHIFT)) dut (
    .clk(clk), .rst(rst), .cal_req(cal_req), .cal_busy(cal_busy),
    .shift_busy(shift_busy), .shift_sel(shift_sel), .shift_en(shift_en),
    .load_strobe(load_strobe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // channel index of a one-hot vector, -1 otherwise
  function automatic int sel_index(input logic [N-1:0] v);
    int r = -1;
    if ($countones(v) == 1)
      for (int i = 0; i < N; i++) if (v[i]) r = i;
    return r;
  endfunction

  // edges from capture to the strobe, walked slot by slot
  function automatic int strobe_edge(input logic [N-1:0] m);
    int hi = 0;
    int t = CAL;
    for (int i = 0; i < N; i++) if (m[i]) hi = i;
    for (int i = 0; i <= hi; i++) begin
      t += m[i] ? (SHIFT + 3) : 1;
      if (i < hi) t += 1;
    end
    return t;
  endfunction

  task automatic run_vec(input logic [N-1:0] mask, input logic [N-1:0] inj, input int inj_at);
    int n = 0;
    int cur = -1;
    int runlen = 0;
    int last_ch = -1;
    int loads = 0;
    int exp_ld;
    int ch;
    int last_sh [N];
    logic [N-1:0] seen = '0;
    logic [N-1:0] prev_sb = '0;
    exp_ld = 2 + strobe_edge(mask);
    for (int i = 0; i < N; i++) last_sh[i] = 0;
    @(negedge clk);
    cal_req = mask;
    while (n < exp_ld + 3) begin
      @(negedge clk);
      n++;
      if (n == 2) cal_req = '0;
      if (inj_at != 0 && n == inj_at) cal_req = inj;
      if (inj_at != 0 && n == inj_at + 3) cal_req = '0;
      if (n == 2) begin
        chk(cal_busy == mask, "R3 cal_busy at capture", int'(cal_busy), int'(mask));
        chk(shift_busy == mask, "R3 shift_busy at capture", int'(shift_busy), int'(mask));
      end
      if (n == 1 + CAL) chk(cal_busy == mask, "R4 cal_busy held", int'(cal_busy), int'(mask));
      if (n == 2 + CAL) chk(cal_busy == '0, "R4 cal_busy cleared", int'(cal_busy), 0);
      if (inj_at != 0 && n == inj_at + 3)
        chk((shift_busy & inj) == '0 && (cal_busy & inj) == '0, "R8 injected request ignored",
            int'(shift_busy), int'(shift_busy & ~inj));
      if (shift_en) begin
        ch = sel_index(shift_sel);
        chk(ch >= 0, "R5 shift_sel one-hot", int'(shift_sel), 1);
        if (ch >= 0 && ch != cur) begin
          chk(ch > last_ch, "R5 ascending order", ch, last_ch + 1);
          chk(mask[ch], "R5 channel requested", ch, int'(mask));
          chk(cal_busy == '0, "R5 no shift during calibration", int'(cal_busy), 0);
          cur = ch; last_ch = ch; runlen = 1; seen[ch] = 1'b1;
        end else begin
          runlen++;
        end
        if (ch >= 0) last_sh[ch] = n;
      end else begin
        chk(shift_sel == '0, "R5 select idle", int'(shift_sel), 0);
        if (cur >= 0) chk(runlen == SHIFT, "R5 shift length", runlen, SHIFT);
        cur = -1;
      end
      for (int i = 0; i < N; i++)
        if (prev_sb[i] && !shift_busy[i])
          chk(n - last_sh[i] == 2, "R6 shift_busy clear timing", n - last_sh[i], 2);
      prev_sb = shift_busy;
      if (load_strobe) begin
        loads++;
        chk(n == exp_ld, "R7 strobe edge", n, exp_ld);
        chk(shift_busy == '0 && cal_busy == '0, "R7 busy clear at strobe", int'(shift_busy), 0);
      end
    end
    chk(seen == mask, "R5 channels shifted", int'(seen), int'(mask));
    chk(loads == 1, "R7 single strobe", loads, 1);
    chk(shift_busy == '0 && cal_busy == '0, "R7 quiet after run", int'(shift_busy | cal_busy), 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !ended) begin
      ended = 1'b1;
      nfail++;
      nchk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 60000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int act;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cal_busy == '0 && shift_busy == '0 && shift_sel == '0 && !shift_en && !load_strobe,
        "R1 reset state", int'(cal_busy | shift_busy | shift_sel), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // table of request masks
    for (int v = 0; v < NVEC; v++) begin
      run_vec(VEC[v], '0, 0);
      repeat (2) @(negedge clk);
    end

    // R8: new request while shifting is ignored
    run_vec(6'b000001, 6'b110000, 30);
    repeat (3) @(negedge clk);
    chk(cal_busy == '0 && shift_busy == '0, "R8 nothing pending afterwards",
        int'(cal_busy | shift_busy), 0);

    // R2: single-edge pulse is not captured
    cal_req = 6'b001100;
    @(negedge clk);
    cal_req = '0;
    act = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      act |= int'(cal_busy | shift_busy);
    end
    chk(act == 0, "R2 one-edge pulse ignored", act, 0);

    // R2: value changing between edges, the second value is captured
    cal_req = 6'b000011;
    @(negedge clk);
    cal_req = 6'b010000;
    @(negedge clk);
    chk(cal_busy == '0, "R2 no capture on changed value", int'(cal_busy), 0);
    @(negedge clk);
    cal_req = '0;
    chk(cal_busy == 6'b010000, "R2 capture of held value", int'(cal_busy), 16);
    act = 0;
    for (int i = 0; i < 400 && act == 0; i++) begin
      @(negedge clk);
      if (load_strobe) act = 1;
    end
    chk(act == 1, "R7 strobe after changed request", act, 1);
    repeat (2) @(negedge clk);

    // R1: reset during calibration abandons the sequence
    cal_req = 6'b100001;
    repeat (2) @(negedge clk);
    cal_req = '0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(cal_busy == '0 && shift_busy == '0 && !shift_en && !load_strobe,
        "R1 mid-run reset clears", int'(cal_busy | shift_busy), 0);
    act = 0;
    for (int i = 0; i < CAL + 100; i++) begin
      @(negedge clk);
      if (shift_en || load_strobe || cal_busy != '0) act++;
    end
    chk(act == 0, "R1 no activity after reset", act, 0);

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule